// File: doc/BRIEF.md
# External Bus Yield Controller with SDRAM Precharge

This block decides when a microcontroller lets an outside master take over its external memory bus while a synchronous DRAM shares that bus. An active-low hold request from the outside master is registered on the rising clock edge. The block waits for any external access still in flight to end. It then closes every SDRAM bank with a single precharge-all command, followed by a short stretch of NOP commands. Only after that does it float its bus drivers and pull the active-low grant line low.

While the bus is away, the chip may need it back. An internal master may have an external access waiting, or the auto-refresh logic may be asking for a refresh cycle. If the request-out feature is enabled, the block then pulls an active-low request-out line low to ask the outside master to let go. The outside master gives the bus back by raising its request. The grant then rises and the drivers are enabled again. Request-out clears one and a half clock periods after the grant rises. A refresh-triggered request-out is an exception: it stays low until the refresh cycle actually starts. Internal masters watch a stall flag that stays high for the whole hand-over.

Top module: `ext_bus_yield_ctl`

## Requirements
- R1: After reset, grant_n=1, reqout_n=1, bus_released=0, drive_en=1, sd_cmd=3'b111 (NOP), sd_allbank=0 and cke=1.
- R2: sd_cmd bits are {RAS_n, CAS_n, WE_n}. A low bus_req_n registered at edge k, with acc_active low, puts the precharge-all command (sd_cmd=3'b010, sd_allbank=1) on the outputs for exactly the cycle after edge k+1. NOP (3'b111, sd_allbank=0) follows after edge k+2. The grant stays high until after edge k+3.
- R3: While acc_active is high at a clock edge, no precharge-all is issued. The command comes after the first edge that samples acc_active low.
- R4: The grant falls after the last NOP cycle. From then on, grant_n=0 and drive_en=0 (address, data and command pins floated), and cke stays 1.
- R5: A high bus_req_n registered at edge m keeps the grant low through edge m. After edge m+1, grant_n=1, drive_en=1 and bus_released=0.
- R6: bus_released is high from the precharge-all cycle until the grant rises again.
- R7: With reqout_en=1, an int_demand or refresh_req that is high at an edge during the release pulls reqout_n low at the following falling edge. It stays low for the rest of the release even if the demand drops.
- R8: Without a pending refresh, reqout_n returns high at the falling edge 1.5 clock periods after the grant rises.
- R9: If refresh_req caused the request-out, reqout_n stays low after the bus returns. It goes high at the falling edge that follows the first edge sampling refresh_started high.
- R10: With reqout_en=0, reqout_n stays high whatever the internal demand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Active-low hold request from the outside master |
| acc_active | input | 1 | High while an external access cycle is in progress |
| reqout_en | input | 1 | Enables the request-out line |
| int_demand | input | 1 | An internal master has an external access waiting |
| refresh_req | input | 1 | Auto-refresh wants the bus |
| refresh_started | input | 1 | The auto-refresh cycle has begun |
| grant_n | output | 1 | Active-low bus grant |
| reqout_n | output | 1 | Active-low request for the bus back |
| bus_released | output | 1 | Stall flag for internal masters |
| drive_en | output | 1 | Enables address, data and SDRAM command drivers |
| sd_cmd | output | 3 | SDRAM command {RAS_n, CAS_n, WE_n} |
| sd_allbank | output | 1 | Precharge-select (all banks) line |
| cke | output | 1 | SDRAM clock enable |

## Verification
The hardest case to reach from the ports is the refresh hold. The grant has already risen, yet reqout_n must stay low until a refresh-start pulse arrives several cycles later. It must then clear on a falling edge, not a rising one. The stimulus has three steps. It raises refresh_req for a single cycle during a release. It returns the bus with refresh_started held low for a few cycles. It then pulses refresh_started. The monitor samples both after the rising edge and after the falling edge, so the half-cycle timing is visible. A second release, with int_demand held across the return, shows the normal 1.5-period clearing for comparison.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  typedef enum logic [1:0] {
    ST_OWN    = 2'd0,
    ST_PALL   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_YIELD  = 2'd3
  } yield_st_e;

  // SDRAM command encoding {RAS_n, CAS_n, WE_n}
  localparam logic [2:0] CMD_NOP  = 3'b111;
  localparam logic [2:0] CMD_PALL = 3'b010;
endpackage

// File: rtl/ebr_req_sync.sv
module ebr_req_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic dout_n
);
  localparam int N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] chain;

  generate
    if (N == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= din_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[N-2:0], din_n};
      end
    end
  endgenerate

  assign dout_n = chain[N-1];
endmodule

// File: rtl/ebr_yield_fsm.sv
module ebr_yield_fsm
  import ebr_pkg::*;
#(
  parameter int NOP_GAP = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_n_q,
  input  logic      acc_active,
  output yield_st_e state,
  output logic [2:0] sd_cmd,
  output logic      sd_allbank
);
  localparam int GAP = (NOP_GAP < 1) ? 1 : NOP_GAP;
  localparam int GW  = (GAP > 1) ? $clog2(GAP) : 1;

  yield_st_e st, st_nx;
  logic [GW-1:0] gap_cnt, cnt_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OWN;
      gap_cnt <= '0;
    end else begin
      st      <= st_nx;
      gap_cnt <= cnt_nx;
    end
  end

  always_comb begin
    st_nx  = st;
    cnt_nx = gap_cnt;
    case (st)
      ST_OWN: begin
        if (!req_n_q && !acc_active) st_nx = ST_PALL;
      end
      ST_PALL: begin
        st_nx  = ST_SETTLE;
        cnt_nx = GW'(GAP - 1);
      end
      ST_SETTLE: begin
        if (gap_cnt == '0) st_nx = ST_YIELD;
        else               cnt_nx = gap_cnt - GW'(1);
      end
      ST_YIELD: begin
        if (req_n_q) st_nx = ST_OWN;
      end
      default: st_nx = ST_OWN;
    endcase
  end

  assign state      = st;
  assign sd_cmd     = (st == ST_PALL) ? CMD_PALL : CMD_NOP;
  assign sd_allbank = (st == ST_PALL);
endmodule

// File: rtl/ebr_reqout_ctl.sv
module ebr_reqout_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic released,
  input  logic en,
  input  logic int_demand,
  input  logic refresh_req,
  input  logic refresh_started,
  output logic reqout_n
);
  logic rq_post;
  logic rf_hold;
  logic rq_neg;

  // rising-edge decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_post <= 1'b0;
      rf_hold <= 1'b0;
    end else if (!en) begin
      rq_post <= 1'b0;
      rf_hold <= 1'b0;
    end else if (released) begin
      if (int_demand || refresh_req) rq_post <= 1'b1;
      if (refresh_req)               rf_hold <= 1'b1;
    end else if (rf_hold) begin
      if (refresh_started) begin
        rq_post <= 1'b0;
        rf_hold <= 1'b0;
      end
    end else begin
      rq_post <= 1'b0;
    end
  end

  // half-cycle output stage
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rq_neg <= 1'b0;
    else        rq_neg <= rq_post;
  end

  assign reqout_n = !rq_neg;
endmodule

// File: rtl/ext_bus_yield_ctl.sv
module ext_bus_yield_ctl
  import ebr_pkg::*;
#(
  parameter int SYNC_STAGES = 1,
  parameter int NOP_GAP     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req_n,
  input  logic       acc_active,
  input  logic       reqout_en,
  input  logic       int_demand,
  input  logic       refresh_req,
  input  logic       refresh_started,
  output logic       grant_n,
  output logic       reqout_n,
  output logic       bus_released,
  output logic       drive_en,
  output logic [2:0] sd_cmd,
  output logic       sd_allbank,
  output logic       cke
);
  logic      req_n_q;
  yield_st_e state;

  ebr_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_n  (bus_req_n),
    .dout_n (req_n_q)
  );

  ebr_yield_fsm #(.NOP_GAP(NOP_GAP)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n_q    (req_n_q),
    .acc_active (acc_active),
    .state      (state),
    .sd_cmd     (sd_cmd),
    .sd_allbank (sd_allbank)
  );

  ebr_reqout_ctl u_rqo (
    .clk             (clk),
    .rst_n           (rst_n),
    .released        (state == ST_YIELD),
    .en              (reqout_en),
    .int_demand      (int_demand),
    .refresh_req     (refresh_req),
    .refresh_started (refresh_started),
    .reqout_n        (reqout_n)
  );

  assign grant_n      = (state != ST_YIELD);
  assign drive_en     = (state != ST_YIELD);
  assign bus_released = (state != ST_OWN);
  assign cke          = 1'b1;
endmodule

// File: rtl/ebr_checker.sv
module ebr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_active,
  input logic       reqout_en,
  input logic       grant_n,
  input logic       reqout_n,
  input logic [2:0] sd_cmd,
  input logic       sd_allbank
);
  a_r2_pall_single: assert property (@(posedge clk) disable iff (!rst_n)
    sd_allbank |=> (!sd_allbank && sd_cmd == 3'b111));

  a_r3_pall_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    sd_allbank |-> $past(!acc_active));

  a_r4_grant_after_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> $past(sd_cmd == 3'b111 && !sd_allbank));

  a_r7_reqout_in_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reqout_n) |-> ($past(!grant_n) && $past(reqout_en)));

  a_r8_reqout_clear_after_return: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reqout_n) |-> (grant_n || $past(!reqout_en)));

  a_r10_reqout_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!reqout_en) |-> reqout_n);
endmodule

bind ext_bus_yield_ctl ebr_checker u_ebr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_active (acc_active),
  .reqout_en  (reqout_en),
  .grant_n    (grant_n),
  .reqout_n   (reqout_n),
  .sd_cmd     (sd_cmd),
  .sd_allbank (sd_allbank)
);

// File: tb/tb_ext_bus_yield_ctl.sv
module tb_ext_bus_yield_ctl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, bus_req_n, acc_active, reqout_en, int_demand, refresh_req, refresh_started;
  logic grant_n, reqout_n, bus_released, drive_en, sd_allbank, cke;
  logic [2:0] sd_cmd;

  ext_bus_yield_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .acc_active(acc_active),
    .reqout_en(reqout_en), .int_demand(int_demand), .refresh_req(refresh_req),
    .refresh_started(refresh_started), .grant_n(grant_n), .reqout_n(reqout_n),
    .bus_released(bus_released), .drive_en(drive_en), .sd_cmd(sd_cmd),
    .sd_allbank(sd_allbank), .cke(cke)
  );

  localparam logic [8:0] M_GNT = 9'h100, M_RQO = 9'h080, M_BRL = 9'h040, M_DRV = 9'h020;
  localparam logic [8:0] M_CMD = 9'h01C, M_ALL = 9'h002, M_CKE = 9'h001;
  localparam logic [2:0] NOP = 3'b111, PALL = 3'b010;

  wire [8:0] obs = {grant_n, reqout_n, bus_released, drive_en, sd_cmd, sd_allbank, cke};

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int         c;
    bit         ph;
    logic [8:0] m;
    logic [8:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [8:0] f_cmd(logic [2:0] c);
    return {4'b0, c, 2'b0};
  endfunction

  task automatic expect_at(int c, bit ph, logic [8:0] m, logic [8:0] v, string tag);
    exp_t e;
    e.c = c; e.ph = ph; e.m = m; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // monitor: pops expected items as their sample point arrives
  task automatic scan(bit ph);
    while (q.size() > 0 && (q[0].c < cyc || (q[0].c == cyc && q[0].ph <= ph))) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (e.c != cyc || e.ph != ph) begin
        n_fail++;
        $display("FAIL %s: sample point %0d/%0d missed, actual=%b expected=%b", e.tag, e.c, e.ph, obs & e.m, e.v & e.m);
      end else if ((obs & e.m) !== (e.v & e.m)) begin
        n_fail++;
        $display("FAIL %s: cycle %0d phase %0d actual=%b expected=%b", e.tag, cyc, ph, obs & e.m, e.v & e.m);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #3 scan(1'b0);
      #5 scan(1'b1);
    end
  end

  task automatic do_release(int busy, string tg);
    int n = cyc;
    int p = (busy + 1 > 2) ? n + busy + 1 : n + 2;
    bus_req_n  = 1'b0;
    acc_active = (busy > 0);
    for (int c = n + 1; c < p; c++)
      expect_at(c, 1'b0, M_GNT | M_BRL | M_ALL | M_CMD, M_GNT | f_cmd(NOP), tg);
    expect_at(p,     1'b0, M_GNT | M_BRL | M_ALL | M_CMD, M_GNT | M_BRL | M_ALL | f_cmd(PALL), tg);
    expect_at(p + 1, 1'b0, M_GNT | M_BRL | M_ALL | M_CMD, M_GNT | M_BRL | f_cmd(NOP), tg);
    expect_at(p + 2, 1'b0, M_GNT | M_DRV | M_BRL | M_CKE, M_BRL | M_CKE, "R4 bus granted and floated");
    while (cyc < p + 2) begin
      tick();
      if (cyc == n + busy) acc_active = 1'b0;
    end
  endtask

  task automatic do_return();
    int m = cyc;
    bus_req_n = 1'b1;
    expect_at(m + 1, 1'b0, M_GNT | M_DRV, 9'h000, "R5 grant held one more cycle");
    expect_at(m + 2, 1'b0, M_GNT | M_DRV | M_BRL, M_GNT | M_DRV, "R5 bus taken back");
    while (cyc < m + 2) tick();
  endtask

  initial begin
    int n, m;
    rst_n = 1'b0; bus_req_n = 1'b1; acc_active = 1'b0; reqout_en = 1'b0;
    int_demand = 1'b0; refresh_req = 1'b0; refresh_started = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    expect_at(cyc + 1, 1'b0, 9'h1FF, M_GNT | M_RQO | M_DRV | f_cmd(NOP) | M_CKE, "R1 reset state");
    repeat (2) tick();

    // plain release and return
    do_release(0, "R2/R6 basic release");
    n = cyc;
    expect_at(n + 2, 1'b0, M_GNT | M_DRV | M_BRL, M_BRL, "R4 release holds");
    repeat (3) tick();
    do_return();
    repeat (2) tick();

    // access in progress defers precharge
    do_release(3, "R3 deferred by access");
    do_return();
    tick();
    do_release(1, "R3 access ends at once");
    do_return();
    tick();

    // request-out from internal demand
    reqout_en = 1'b1;
    do_release(0, "R2 release with request-out");
    n = cyc;
    int_demand = 1'b1;
    expect_at(n + 1, 1'b0, M_RQO, M_RQO, "R7 not before falling edge");
    expect_at(n + 1, 1'b1, M_RQO, 9'h000, "R7 request-out asserted");
    expect_at(n + 4, 1'b1, M_RQO, 9'h000, "R7 held after demand drops");
    tick(); tick();
    int_demand = 1'b0;
    while (cyc < n + 4) tick();
    int_demand = 1'b1;
    do_return();
    m = cyc - 2;
    expect_at(m + 2, 1'b1, M_RQO, 9'h000, "R8 still low at grant rise");
    expect_at(m + 3, 1'b0, M_RQO, 9'h000, "R8 still low one period later");
    expect_at(m + 3, 1'b1, M_RQO, M_RQO, "R8 cleared 1.5 periods after grant");
    while (cyc < m + 4) tick();
    int_demand = 1'b0;
    tick();

    // request-out from refresh: held until refresh starts
    do_release(0, "R6 release for refresh");
    n = cyc;
    refresh_req = 1'b1;
    expect_at(n + 1, 1'b1, M_RQO, 9'h000, "R7 refresh request-out");
    tick();
    refresh_req = 1'b0;
    tick();
    do_return();
    m = cyc - 2;
    expect_at(m + 3, 1'b1, M_RQO, 9'h000, "R9 held past grant rise");
    expect_at(m + 5, 1'b1, M_RQO, 9'h000, "R9 held until refresh starts");
    while (cyc < m + 5) tick();
    refresh_started = 1'b1;
    expect_at(m + 6, 1'b0, M_RQO, 9'h000, "R9 low at start edge");
    expect_at(m + 6, 1'b1, M_RQO, M_RQO, "R9 cleared after refresh start");
    tick();
    refresh_started = 1'b0;
    tick();

    // request-out disabled
    reqout_en = 1'b0;
    do_release(0, "R2 release with request-out off");
    n = cyc;
    int_demand = 1'b1;
    refresh_req = 1'b1;
    for (int k = 1; k <= 3; k++) expect_at(n + k, 1'b1, M_RQO, M_RQO, "R10 request-out stays high");
    repeat (3) tick();
    int_demand = 1'b0;
    refresh_req = 1'b0;
    do_return();
    m = cyc - 2;
    expect_at(m + 3, 1'b1, M_RQO | M_CKE, M_RQO | M_CKE, "R10 still high after return");
    repeat (4) tick();

    while (q.size() > 0) tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule